// File: doc/BRIEF.md
# Four-Sensor Falling-Edge Tally with Held Report Strobe

This block keeps a running tally of items leaving a machine through four independent outlets, each watched by an optical sensor. A sensor line rests at 0 and reads 1 while an item blocks its beam. One item is counted each time a line drops from 1 to 0. The drop is found by comparing each line with its value at the previous clock edge. Sensor lines are taken as clean and synchronous to the clock, so no filter is applied. Falls on several sensors in the same cycle are all added to the tally in one step.

A one-cycle report request copies the tally onto a 15-bit output bus and raises a ready strobe. The strobe stays high for a fixed number of clock cycles, `HOLD_CYCLES`, and then drops. The bus keeps its value. For example, 150 cycles at 50 MHz gives the 3 µs minimum hold. The report logic is a two-state machine:
- `RPT_IDLE` (strobe low) moves to `RPT_HOLD` on the transition *accept*, which is a request seen while idle.
- `RPT_HOLD` (strobe high) returns to `RPT_IDLE` on the transition *expire*, which fires when the hold timer reaches zero.
- In all other cases each state stays where it is.

Counting never pauses during a report.

Top module: `sensor_tally_report`

## Requirements
- R1: While reset is asserted, and after its release until the first report, `tally_o` is 0 and `ready_o` is 0. The internal tally and the sensor history are both cleared to 0.
- R2: A sensor bit that reads 1 at one clock edge and 0 at the next adds exactly one to the tally at that second edge. A 0-to-1 change adds nothing, and a steady level adds nothing.
- R3: Falls on any subset of the four sensors at the same edge are all added at that edge, so one edge can add 0 to 4.
- R4: The tally is 15 bits wide and wraps modulo 32768.
- R5: A request (`report_req_i` = 1) sampled at an edge while `ready_o` is 0 is accepted. At that edge `tally_o` takes the tally as it stood before the edge, so falls detected at the same edge are not included, and `ready_o` goes to 1.
- R6: After an accepted request, `ready_o` stays 1 for exactly `HOLD_CYCLES` clock cycles and then returns to 0.
- R7: `tally_o` changes only at an accepted request. It stays unchanged when `ready_o` falls and stays unchanged afterwards.
- R8: A request sampled while `ready_o` is 1 is ignored. Neither `tally_o` nor the hold timing changes.
- R9: Falls that occur while `ready_o` is 1 are still counted and appear in the next report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sens_i | input | 4 | Sensor lines; 1 while an item blocks the beam |
| report_req_i | input | 1 | One-cycle report request |
| tally_o | output | 15 | Tally value latched at the last accepted report |
| ready_o | output | 1 | Data-ready strobe, high for `HOLD_CYCLES` cycles |

## Verification
- **Strobe faults show at once.** A wrong report state or hold timer shows on `ready_o` as soon as it occurs. The strobe rises late, stays high too long or too briefly, or ignores a request it should accept.
- **Tally faults show late.** A wrong internal tally or sensor history cannot be seen until the next report. Then the bus shows a value off from the arithmetic sum of all falls so far.
- **How the bench reaches every pattern.** It sweeps every ordered pair of 4-bit sensor samples and reports after each pair. A miscount therefore surfaces within about ten cycles of the pattern that caused it.
- **Other cases covered.** The bench also tests modular wrap, a fall in the same cycle as a request, and requests made during the hold.

// File: rtl/sntally_pkg.sv
package sntally_pkg;

    typedef enum logic [0:0] {
        RPT_IDLE = 1'b0,
        RPT_HOLD = 1'b1
    } rpt_state_e;

endpackage

// File: rtl/snt_fall_detect.sv
module snt_fall_detect #(
    parameter int NUM_SENS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SENS-1:0] sens_i,
    output logic [NUM_SENS-1:0] fall_o
);

    logic [NUM_SENS-1:0] hist_q;

    // History of the previous sample; cleared so a line high at reset is not a fall.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= sens_i;
        end
    end

    for (genvar g = 0; g < NUM_SENS; g++) begin : g_lane
        assign fall_o[g] = hist_q[g] & ~sens_i[g];
    end

endmodule

// File: rtl/snt_accum.sv
module snt_accum #(
    parameter int NUM_SENS = 4,
    parameter int CNT_W    = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SENS-1:0] fall_i,
    output logic [CNT_W-1:0]    total_o
);

    localparam int PC_W = $clog2(NUM_SENS + 1);

    logic [PC_W-1:0]  ones;
    logic [CNT_W-1:0] total_q;

    always_comb begin
        ones = '0;
        for (int i = 0; i < NUM_SENS; i++) begin
            ones = ones + PC_W'(fall_i[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_q <= '0;
        end else begin
            total_q <= total_q + CNT_W'(ones);
        end
    end

    assign total_o = total_q;

    // R3: a single edge never advances the tally by more than the sensor count (mod 2^CNT_W)
    a_r3_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(total_q - $past(total_q)) <= CNT_W'(NUM_SENS));

    // R2: with no falls presented, the tally holds
    a_r2_no_fall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i == '0) |=> $stable(total_q));

endmodule

// File: rtl/snt_report.sv
module snt_report
    import sntally_pkg::*;
#(
    parameter int CNT_W       = 15,
    parameter int HOLD_CYCLES = 150
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [CNT_W-1:0] total_i,
    output logic [CNT_W-1:0] bus_o,
    output logic             rdy_o
);

    localparam int TMR_W = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES + 1);

    rpt_state_e       state_q, state_d;
    logic [TMR_W-1:0] tmr_q;
    logic [CNT_W-1:0] bus_q;
    logic             accept, expire;

    assign accept = (state_q == RPT_IDLE) && req_i;
    assign expire = (state_q == RPT_HOLD) && (tmr_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RPT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RPT_IDLE: if (accept) state_d = RPT_HOLD;
            RPT_HOLD: if (expire) state_d = RPT_IDLE;
            default:  state_d = RPT_IDLE;
        endcase
    end

    // outputs: latched bus and hold timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q <= '0;
            tmr_q <= '0;
        end else begin
            unique case (state_q)
                RPT_IDLE: begin
                    if (accept) begin
                        bus_q <= total_i;
                        tmr_q <= TMR_W'(HOLD_CYCLES - 1);
                    end
                end
                RPT_HOLD: begin
                    if (!expire) tmr_q <= tmr_q - 1'b1;
                end
                default: tmr_q <= '0;
            endcase
        end
    end

    assign bus_o = bus_q;
    assign rdy_o = (state_q == RPT_HOLD);

    // run-length of the strobe, for the hold-window check
    logic [31:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= '0;
        else if (rdy_o)  run_q <= run_q + 1;
        else             run_q <= '0;
    end

    // R5: an accepted request raises the strobe at the next edge
    a_r5_accept_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !rdy_o) |=> rdy_o);

    // R5: the bus takes the pre-edge tally on acceptance
    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !rdy_o) |=> (bus_o == $past(total_i)));

    // R6: the strobe falls only after exactly HOLD_CYCLES high cycles
    a_r6_hold_exact: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_o) |-> (run_q == 32'(HOLD_CYCLES)));

    // R6: the strobe never outlives its window
    a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 32'(HOLD_CYCLES));

    // R7/R8: bus is stable unless a request is accepted
    a_r7_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_i && !rdy_o) |=> $stable(bus_o));

endmodule

// File: rtl/sensor_tally_report.sv
module sensor_tally_report #(
    parameter int NUM_SENS    = 4,
    parameter int CNT_W       = 15,
    parameter int HOLD_CYCLES = 150
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SENS-1:0] sens_i,
    input  logic                report_req_i,
    output logic [CNT_W-1:0]    tally_o,
    output logic                ready_o
);

    logic [NUM_SENS-1:0] fall;
    logic [CNT_W-1:0]    total;

    snt_fall_detect #(
        .NUM_SENS(NUM_SENS)
    ) u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .sens_i (sens_i),
        .fall_o (fall)
    );

    snt_accum #(
        .NUM_SENS(NUM_SENS),
        .CNT_W   (CNT_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall_i  (fall),
        .total_o (total)
    );

    snt_report #(
        .CNT_W      (CNT_W),
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_report (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (report_req_i),
        .total_i (total),
        .bus_o   (tally_o),
        .rdy_o   (ready_o)
    );

    // R8: a request during the strobe leaves the bus untouched
    a_r8_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && report_req_i) |=> $stable(tally_o));

    // R1: outputs idle in reset
    always_comb begin
        if (!rst_n) begin
            a_r1_reset_idle: assert (ready_o == 1'b0 && tally_o == '0);
        end
    end

endmodule

// File: tb/test_sensor_tally_report.sv
module test_sensor_tally_report;

    localparam int NS   = 4;
    localparam int W    = 15;
    localparam int HOLD = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] sens = '0;
    logic          req = 1'b0;
    logic [W-1:0]  tally;
    logic          ready;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [W-1:0]  model = '0;
    logic [NS-1:0] prev  = '0;

    sensor_tally_report #(
        .NUM_SENS(NS), .CNT_W(W), .HOLD_CYCLES(HOLD)
    ) i_sensor_tally_report (
        .clk(clk), .rst_n(rst_n), .sens_i(sens), .report_req_i(req),
        .tally_o(tally), .ready_o(ready)
    );

    always #2 clk = ~clk;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive a new sensor sample; the fall is counted at the next edge
    task automatic set_sens(input logic [NS-1:0] v);
        model = model + W'($countones(prev & ~v));
        prev  = v;
        sens  = v;
        tick();
    endtask

    // issue request, check capture, strobe length and bus stability
    task automatic report_check(input string tag);
        logic [W-1:0] snap;
        int n;
        snap = model;
        req = 1'b1;
        tick();
        req = 1'b0;
        check(ready == 1'b1, {tag, " R5 strobe up"}, int'(ready), 1);
        check(tally == snap, {tag, " R5 captured"}, int'(tally), int'(snap));
        n = 1;
        for (int k = 0; k < 50; k++) begin
            tick();
            if (!ready) break;
            n++;
        end
        check(n == HOLD, {tag, " R6 hold length"}, n, HOLD);
        check(tally == snap, {tag, " R7 bus kept at drop"}, int'(tally), int'(snap));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] snap;
        repeat (3) tick();
        // R1: during reset
        check(tally == '0, "R1 bus in reset", int'(tally), 0);
        check(ready == 1'b0, "R1 strobe in reset", int'(ready), 0);
        rst_n = 1'b1;
        repeat (2) tick();
        check(tally == '0 && ready == 1'b0, "R1 after release", int'({ready, tally}), 0);
        report_check("R1 zero tally");

        // R2/R3: every ordered pair of sensor samples
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                set_sens(NS'(a));
                set_sens(NS'(b));
                report_check($sformatf("R2 R3 pair %0h->%0h", a, b));
            end
        end
        set_sens('0);

        // R5: fall at the same edge as the request is excluded
        set_sens(4'hF);
        snap = model;
        model = model + W'(4);
        prev = '0;
        sens = '0;
        req = 1'b1;
        tick();
        req = 1'b0;
        check(tally == snap, "R5 same-edge fall excluded", int'(tally), int'(snap));
        while (ready) tick();
        report_check("R5 same-edge fall in next report");

        // R8/R9: requests and falls during the hold
        snap = model;
        req = 1'b1;
        tick();
        req = 1'b0;
        check(tally == snap, "R5 capture before busy test", int'(tally), int'(snap));
        set_sens(4'hA);
        set_sens(4'h0);
        req = 1'b1;
        tick();
        req = 1'b0;
        check(tally == snap, "R8 busy request ignored", int'(tally), int'(snap));
        check(ready == 1'b1, "R8 strobe still up", int'(ready), 1);
        while (ready) tick();
        check(tally == snap, "R7 bus after drop", int'(tally), int'(snap));
        repeat (3) tick();
        check(tally == snap, "R7 bus idle hold", int'(tally), int'(snap));
        report_check("R9 falls during hold counted");

        // R4: wrap modulo 2^15
        for (int k = 0; k < 8192; k++) begin
            set_sens(4'hF);
            set_sens(4'h0);
        end
        report_check("R4 full wrap");
        set_sens(4'h7);
        set_sens(4'h0);
        report_check("R4 after wrap");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule